// File: doc/BRIEF.md
# Median-of-Three Coprocessor with Single-Port Operand Loading

This block is a small memory-mapped coprocessor that picks the middle value of three unsigned 32-bit operands. The processor has one write location for data going in and one read location for the answer, so the three operands have to come in one after another through the same location. The block keeps a three-deep operand window. A new operand enters the window only when a write of zero to the input location is followed by a write of a nonzero value there. Each such entry pushes the oldest operand out.

A combinational median selector works on the window as it will be after the arrival. Its answer is registered on the same clock edge that shifts the operand in. Software loads an operand with two stores: a zero, then the value. It repeats this three times and can read the median at the next access without any polling. The result location sits four bytes above the input location. Reading the input location returns the last value written there.

Top module: `med3_copro`

## Requirements
- R1: After reset the three operand slots, the last-written input value and the result are all zero. A read of the result location returns 0 and a read of the input location returns 0.
- R2: A write to the input location (byte offset 0) with nonzero data, when the previous value written there was zero, is an arrival. It shifts the data into the newest operand slot, and the oldest operand is dropped.
- R3: A nonzero write to the input location that follows a nonzero write (with no zero write in between) does not shift the window. The result stays unchanged.
- R4: Writes of zero to the input location never shift the window and never change the result.
- R5: On an arrival the result register takes the unsigned median of the updated window in that same clock cycle. It can be read in the cycle right after the write.
- R6: The result is read at byte offset 4, which is the input offset plus 4. A read at offset 0 returns the last value written to the input location. A read at any other offset returns 0.
- R7: Writes to the result location or to any offset other than 0 have no effect on the window, the result or the last-written value.
- R8: When two or three of the window values are equal, the result is that repeated value whenever it is the median.
- R9: Slots not yet loaded since reset hold zero and take part in the median. After one arrival of x the result is 0. After arrivals x and y it is min(x, y).
- R10: The window slides. After a fourth arrival the median is taken over the three most recent operands only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per store |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the read |
| rd_data | output | 32 | Read data (combinational from registers) |

## Verification
A wrong arrival detector shows up as a wrong median one operand later. A window that shifted on a repeated nonzero write, or on a zero write, pushes a stale or spurious value into the middle. The next genuine arrival then gives a result that differs from the one computed over the three true operands. The bench therefore follows every ignored-write stimulus with a real arrival whose expected median separates the two cases. A bad selector or a missing same-cycle update appears in the very first read after the third operand, and a wrong address decode appears on the read-back of the input location.

// File: rtl/med3_pkg.sv
package med3_pkg;
  localparam int unsigned IN_OFS  = 0;
  localparam int unsigned OUT_OFS = IN_OFS + 4;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_INPUT  = 2'd1,
    RD_RESULT = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/med3_arrival.sv
module med3_arrival #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_wr,
  input  logic [DATA_W-1:0] in_data,
  output logic              arrive,
  output logic [DATA_W-1:0] last_val
);
  logic [DATA_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_q <= '0;
    else if (in_wr) last_q <= in_data;
  end

  assign arrive   = in_wr && (last_q == '0) && (in_data != '0);
  assign last_val = last_q;

  // R6: the remembered value follows the most recent input write
  a_r6_last_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    in_wr |=> last_q == $past(in_data));
  // R7: without an input write the remembered value holds
  a_r7_last_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_wr |=> $stable(last_q));
endmodule

// File: rtl/med3_window.sv
module med3_window #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    shift,
  input  logic [DATA_W-1:0]       din,
  output logic [DEPTH*DATA_W-1:0] slots
);
  logic [DATA_W-1:0] slot_q [DEPTH];

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      logic [DATA_W-1:0] feed;
      if (gi == 0) begin : g_head
        assign feed = din;
      end else begin : g_tail
        assign feed = slot_q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     slot_q[gi] <= '0;
        else if (shift) slot_q[gi] <= feed;
      end
      assign slots[gi*DATA_W +: DATA_W] = slot_q[gi];
    end
  endgenerate

  // R2: newest slot receives the shifted-in data
  a_r2_head_loads: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> slot_q[0] == $past(din));
  // R3/R4: no shift, no change anywhere in the window
  a_r4_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(slots));
endmodule

// File: rtl/med3_select.sv
module med3_select #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] c,
  output logic [DATA_W-1:0] mid
);
  function automatic logic [DATA_W-1:0] umin(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    return (x < y) ? x : y;
  endfunction

  function automatic logic [DATA_W-1:0] umax(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    return (x < y) ? y : x;
  endfunction

  // middle = larger of (smaller pair member) and (larger pair member clipped by c)
  function automatic logic [DATA_W-1:0] median3(input logic [DATA_W-1:0] x,
                                                input logic [DATA_W-1:0] y,
                                                input logic [DATA_W-1:0] z);
    return umax(umin(x, y), umin(umax(x, y), z));
  endfunction

  assign mid = median3(a, b, c);
endmodule

// File: rtl/med3_copro.sv
module med3_copro #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  import med3_pkg::*;

  localparam int unsigned DEPTH = 3;
  localparam logic [ADDR_W-1:0] IN_A  = ADDR_W'(IN_OFS);
  localparam logic [ADDR_W-1:0] OUT_A = ADDR_W'(OUT_OFS);

  logic                    in_wr;
  logic                    arrive;
  logic [DATA_W-1:0]       last_val;
  logic [DEPTH*DATA_W-1:0] slots;
  logic [DATA_W-1:0]       s0, s1, s2;
  logic [DATA_W-1:0]       mid_next;
  logic [DATA_W-1:0]       res_q;
  rd_sel_e                 rd_sel;

  assign in_wr = wr_en && (wr_addr == IN_A);

  med3_arrival #(.DATA_W(DATA_W)) u_arrival (
    .clk(clk), .rst_n(rst_n), .in_wr(in_wr), .in_data(wr_data),
    .arrive(arrive), .last_val(last_val)
  );

  med3_window #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_window (
    .clk(clk), .rst_n(rst_n), .shift(arrive), .din(wr_data), .slots(slots)
  );

  assign s0 = slots[0*DATA_W +: DATA_W];
  assign s1 = slots[1*DATA_W +: DATA_W];
  assign s2 = slots[2*DATA_W +: DATA_W];

  // median over the window as it stands after this arrival
  med3_select #(.DATA_W(DATA_W)) u_select (
    .a(wr_data), .b(s0), .c(s1), .mid(mid_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (arrive) res_q <= mid_next;
  end

  always_comb begin
    if (rd_addr == OUT_A)     rd_sel = RD_RESULT;
    else if (rd_addr == IN_A) rd_sel = RD_INPUT;
    else                      rd_sel = RD_NONE;
  end

  always_comb begin
    case (rd_sel)
      RD_RESULT: rd_data = res_q;
      RD_INPUT:  rd_data = last_val;
      default:   rd_data = '0;
    endcase
  end

  // R5: after an arrival the result ranks in the middle of the window
  a_r5_result_is_middle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(arrive) |->
      (((res_q >= s0) ? 1 : 0) + ((res_q >= s1) ? 1 : 0) + ((res_q >= s2) ? 1 : 0) >= 2) &&
      (((res_q <= s0) ? 1 : 0) + ((res_q <= s1) ? 1 : 0) + ((res_q <= s2) ? 1 : 0) >= 2) &&
      ((res_q == s0) || (res_q == s1) || (res_q == s2)));
  // R3: a nonzero write after a nonzero write leaves the result alone
  a_r3_repeat_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr && last_val != '0) |=> $stable(res_q));
  // R7: writes elsewhere leave the result alone
  a_r7_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != IN_A) |=> $stable(res_q));
  // R1: result register reads zero straight out of reset
  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> res_q == '0);
endmodule

// File: tb/med3_copro_bench.sv
module med3_copro_bench;
  localparam int W = 32;
  localparam int A = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [A-1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [A-1:0] rd_addr = '0;
  logic [W-1:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;

  med3_copro u_med3_copro (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  // expected median by sorting three values
  function automatic logic [W-1:0] ref_mid(input logic [W-1:0] p, input logic [W-1:0] q, input logic [W-1:0] r);
    logic [W-1:0] t;
    if (p > q) begin t = p; p = q; q = t; end
    if (q > r) begin t = q; q = r; r = t; end
    if (p > q) begin t = p; p = q; q = t; end
    return q;
  endfunction

  task automatic store(input logic [A-1:0] ad, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ad; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic push(input logic [W-1:0] d);
    store(8'd0, 32'd0);
    store(8'd0, d);
  endtask

  task automatic expect_rd(input logic [A-1:0] ad, input logic [W-1:0] exp, input string req);
    rd_addr = ad;
    #1;
    n_cmp++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s: addr %0d read %0d expected %0d", req, ad, rd_data, exp);
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset();
    expect_rd(8'd4, 32'd0, "R1 result");
    expect_rd(8'd0, 32'd0, "R1 input");
  endtask

  task automatic t_partial;
    do_reset();
    push(32'd40);
    expect_rd(8'd4, 32'd0, "R9 one operand");
    push(32'd25);
    expect_rd(8'd4, 32'd25, "R9 two operands");
    push(32'd90);
    expect_rd(8'd4, ref_mid(40, 25, 90), "R2 R5 three operands");
  endtask

  task automatic t_patterns;
    do_reset();
    push(32'hFFFF_FFF0); push(32'd1); push(32'h8000_0000);
    expect_rd(8'd4, 32'h8000_0000, "R5 unsigned high values");
    do_reset();
    push(32'd3); push(32'd7); push(32'd5);
    expect_rd(8'd4, 32'd5, "R5 middle last");
  endtask

  task automatic t_repeat;
    do_reset();
    push(32'd10); push(32'd30); push(32'd20);
    expect_rd(8'd4, 32'd20, "R5 base");
    push(32'd50);
    expect_rd(8'd4, 32'd30, "R10 slide");
    store(8'd0, 32'd7);
    expect_rd(8'd4, 32'd30, "R3 repeat write result");
    expect_rd(8'd0, 32'd7, "R6 input readback");
    push(32'd1);
    expect_rd(8'd4, ref_mid(1, 50, 20), "R3 repeat not shifted");
  endtask

  task automatic t_zeros;
    do_reset();
    push(32'd8); push(32'd2); push(32'd6);
    store(8'd0, 32'd0); store(8'd0, 32'd0); store(8'd0, 32'd0);
    expect_rd(8'd4, 32'd6, "R4 zero writes result");
    store(8'd0, 32'd100);
    expect_rd(8'd4, ref_mid(100, 6, 2), "R4 zeros not shifted");
  endtask

  task automatic t_equal;
    do_reset();
    push(32'd9); push(32'd9); push(32'd4);
    expect_rd(8'd4, 32'd9, "R8 pair equal");
    push(32'd9);
    expect_rd(8'd4, 32'd9, "R8 all equal path");
  endtask

  task automatic t_addr;
    do_reset();
    push(32'd11); push(32'd22); push(32'd33);
    store(8'd4, 32'd0); store(8'd4, 32'd999);
    store(8'd12, 32'd0); store(8'd12, 32'd555);
    expect_rd(8'd4, 32'd22, "R7 other address writes");
    expect_rd(8'd0, 32'd33, "R7 input value kept");
    expect_rd(8'd8, 32'd0, "R6 unmapped read");
    push(32'd1);
    expect_rd(8'd4, ref_mid(1, 33, 22), "R7 window untouched");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_partial();
        t_patterns();
        t_repeat();
        t_zeros();
        t_equal();
        t_addr();
      end
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule